// File: doc/BRIEF.md
# Radix-4 Booth Sequential Signed Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits and returns the full `2*WIDTH`-bit signed product. It scans the multiplier operand two bits per step. At each step it looks at a three-bit window, and neighbouring windows share one bit. The lowest window sees an implied zero under bit 0. The value of each window picks a partial product from five choices: zero, plus or minus the multiplicand, or plus or minus twice the multiplicand. The multiplicand is sign-extended to the product width and shifted left by two places after every step, so each partial product carries a weight four times that of the one before it.

A request is accepted by pulsing `start_i` while the block is idle. One recoded digit is then folded into an accumulator on every clock. After `WIDTH/2` steps a one-cycle `done_o` pulse marks a fresh, registered `product_o`. A negative multiplier needs no correction pass, because the recoding already gives the top window a negative weight. `WIDTH` must be even and at least 2.

Top module: `radix4_booth_mult`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy_o` and `done_o` are 0 and `product_o` is all zeros.
- R2: When `start_i` is high and `busy_o` is low at a rising edge, the operands are captured and `busy_o` is high in the following cycle.
- R3: `done_o` goes high exactly `WIDTH/2` rising edges after the accepting edge and lasts one cycle. In that same cycle `busy_o` is already low.
- R4: While `done_o` is high, `product_o` equals the signed product of the operands captured at the accepting edge, truncated to `2*WIDTH` bits, which is exact.
- R5: Step i uses the multiplier bits (b[2i+1], b[2i], b[2i-1]), with b[-1] = 0. The digit value is b[2i] + b[2i-1] - 2*b[2i+1], which lies in {-2..+2}. The digit is applied with weight 4^i, so alternating bit patterns such as 0x55 and 0xAA multiply correctly.
- R6: A negative multiplier gives the correct product with no extra correction step.
- R7: With both operands at the most negative value, the product is +2^(2*WIDTH-2). For the default width this is 16384.
- R8: A `start_i` pulse while `busy_o` is high is ignored. It produces no additional `done_o` pulse and does not alter the running result, and the operand inputs are not sampled during that time.
- R9: `product_o` changes only in a cycle where `done_o` is high, and holds its value otherwise.
- R10: A new request may be accepted in the cycle in which `done_o` is high, so back-to-back requests are spaced `WIDTH/2 + 1` cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request; takes effect only while idle |
| mcand_i | input | WIDTH | Signed multiplicand |
| mplier_i | input | WIDTH | Signed multiplier, Booth-recoded |
| busy_o | output | 1 | High while digits are being accumulated |
| done_o | output | 1 | One-cycle pulse when `product_o` is new |
| product_o | output | 2*WIDTH | Registered signed product |

## Verification
The embedded properties assume that `start_i` is a clean synchronous level. They also assume that operands matter only at the accepting edge, so the bench scrambles `mcand_i` and `mplier_i` after every acceptance and raises `start_i` in the middle of running jobs. A scoreboard queue tracks what each accepted request should produce and the cycle in which it is due. Any `done_o` pulse that the queue does not expect is reported against R8. The operands include both extremes, alternating bit patterns, zero and ±1, along with random pairs issued back to back.

// File: rtl/radix4_pkg.sv
package radix4_pkg;

  // One recoded radix-4 digit: sign, magnitude-two flag, zero flag.
  typedef struct packed {
    logic neg;
    logic dbl;
    logic nil;
  } bdigit_t;

endpackage

// File: rtl/r4_digit_recode.sv
module r4_digit_recode
  import radix4_pkg::*;
(
  input  logic [2:0] win_i,
  output bdigit_t    dig_o
);

  // value = win[1] + win[0] - 2*win[2]
  always_comb begin
    dig_o = '{neg: 1'b0, dbl: 1'b0, nil: 1'b1};
    unique case (win_i)
      3'b000, 3'b111: dig_o = '{neg: 1'b0, dbl: 1'b0, nil: 1'b1};
      3'b001, 3'b010: dig_o = '{neg: 1'b0, dbl: 1'b0, nil: 1'b0};
      3'b011:         dig_o = '{neg: 1'b0, dbl: 1'b1, nil: 1'b0};
      3'b100:         dig_o = '{neg: 1'b1, dbl: 1'b1, nil: 1'b0};
      3'b101, 3'b110: dig_o = '{neg: 1'b1, dbl: 1'b0, nil: 1'b0};
      default:        dig_o = '{neg: 1'b0, dbl: 1'b0, nil: 1'b1};
    endcase
  end

endmodule

// File: rtl/r4_pp_select.sv
module r4_pp_select
  import radix4_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic [PW-1:0] mcand_i,
  input  bdigit_t       dig_i,
  output logic [PW-1:0] pp_o,
  output logic          cin_o
);

  logic [PW-1:0] mag;

  always_comb begin
    if (dig_i.nil)      mag = '0;
    else if (dig_i.dbl) mag = {mcand_i[PW-2:0], 1'b0};
    else                mag = mcand_i;
    // negation: one's complement here, +1 enters as carry-in
    pp_o  = dig_i.neg ? ~mag : mag;
    cin_o = dig_i.neg;
  end

endmodule

// File: rtl/r4_accum.sv
module r4_accum #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          add_i,
  input  logic [PW-1:0] pp_i,
  input  logic          cin_i,
  output logic [PW-1:0] sum_o,
  output logic [PW-1:0] acc_o
);

  logic [PW-1:0] acc_q;

  assign sum_o = acc_q + pp_i + {{(PW-1){1'b0}}, cin_i};
  assign acc_o = acc_q;

  always_ff @(posedge clk) begin
    if (rst)        acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (add_i) acc_q <= sum_o;
  end

  // R9: an idle accumulator keeps its value
  assert_acc_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !add_i) |=> $stable(acc_q));

  // R2: a cleared accumulator starts from zero
  assert_acc_clear_R2: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (acc_q == '0));

endmodule

// File: rtl/radix4_booth_mult.sv
module radix4_booth_mult
  import radix4_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);

  localparam int PW    = 2 * WIDTH;
  localparam int STEPS = WIDTH / 2;
  localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic            busy_q, done_q;
  logic [PW-1:0]   prod_q;
  logic [CW-1:0]   cnt_q;
  logic [WIDTH:0]  mreg_q;   // multiplier with implied zero below bit 0
  logic [PW-1:0]   areg_q;   // sign-extended multiplicand, weight 4^step

  bdigit_t         dig;
  logic [PW-1:0]   pp;
  logic            pp_cin;
  logic [PW-1:0]   acc_sum, acc_val;

  logic accept, last;
  assign accept = start_i && !busy_q;
  assign last   = busy_q && (cnt_q == CW'(STEPS - 1));

  r4_digit_recode u_recode (
    .win_i (mreg_q[2:0]),
    .dig_o (dig)
  );

  r4_pp_select #(.PW(PW)) u_ppsel (
    .mcand_i (areg_q),
    .dig_i   (dig),
    .pp_o    (pp),
    .cin_o   (pp_cin)
  );

  r4_accum #(.PW(PW)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .clr_i (accept),
    .add_i (busy_q),
    .pp_i  (pp),
    .cin_i (pp_cin),
    .sum_o (acc_sum),
    .acc_o (acc_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      prod_q <= '0;
      cnt_q  <= '0;
      mreg_q <= '0;
      areg_q <= '0;
    end else begin
      done_q <= last;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        mreg_q <= {mplier_i, 1'b0};
        areg_q <= {{WIDTH{mcand_i[WIDTH-1]}}, mcand_i};
      end else if (busy_q) begin
        cnt_q  <= cnt_q + 1'b1;
        mreg_q <= {{2{mreg_q[WIDTH]}}, mreg_q[WIDTH:2]};
        areg_q <= {areg_q[PW-3:0], 2'b00};
        if (last) begin
          busy_q <= 1'b0;
          prod_q <= acc_sum;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign product_o = prod_q;

  // R2: an accepted request makes the block busy
  assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);

  // R3: done is a single-cycle pulse
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R3: done follows a busy cycle and finds the block idle
  assert_done_ends_busy_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

  // R9: product only moves together with done
  assert_product_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(product_o));

  // R8: start during a job neither restarts nor stalls the step count
  assert_ignore_start_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !last && start_i) |=> (busy_q && (cnt_q == CW'($past(cnt_q) + 1'b1))));

  // R5: a zero digit leaves the running sum untouched
  assert_zero_digit_R5: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !last && dig.nil) |=> (acc_val == $past(acc_val)));

endmodule

// File: tb/radix4_booth_mult_tb.sv
module radix4_booth_mult_tb;
  localparam int W     = 8;
  localparam int PW    = 2 * W;
  localparam int STEPS = W / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] mcand = '0, mplier = '0;
  logic busy, done;
  logic [PW-1:0] product;

  always #4 clk = ~clk;  // 125 MHz

  radix4_booth_mult #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .mcand_i(mcand), .mplier_i(mplier),
    .busy_o(busy), .done_o(done), .product_o(product)
  );

  typedef struct packed { logic [PW-1:0] prod; logic [31:0] due; } item_t;
  item_t q[$];

  int cyc = 0, checks = 0, failures = 0, issued = 0, completed = 0;
  int last_issue = 0;
  logic prev_done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [PW-1:0] ref_mul(input logic signed [W-1:0] a,
                                            input logic signed [W-1:0] b);
    longint pa, pb;
    pa = a; pb = b;
    return PW'(pa * pb);
  endfunction

  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b);
    item_t it;
    while (busy) @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    it.prod = ref_mul(a, b);
    it.due  = 32'(cyc + 1 + STEPS);
    q.push_back(it);
    last_issue = cyc;
    issued++;
    @(negedge clk);
    start = 1'b0;
    mcand = W'($urandom); mplier = W'($urandom);
    check(busy == 1'b1, "R2", "busy after accept", longint'(busy), 1);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy || q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_done && done)
        check(1'b0, "R3", "done longer than one cycle", 2, 1);
      if (done) begin
        completed++;
        if (q.size() == 0) begin
          check(1'b0, "R8", "unexpected done", 1, 0);
        end else begin
          item_t it;
          it = q.pop_front();
          check(product == it.prod, "R4", "product", longint'($signed(product)),
                longint'($signed(it.prod)));
          check(cyc == int'(it.due), "R3", "done cycle", cyc, int'(it.due));
          check(busy == 1'b0, "R3", "busy low at done", longint'(busy), 0);
        end
      end
    end
    prev_done = done;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R3 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [W-1:0] vals [9];
    logic [PW-1:0] held;
    int t1;
    vals = '{8'h80, 8'h81, 8'hFF, 8'h00, 8'h01, 8'h7F, 8'hFE, 8'h55, 8'hAA};

    // R1: reset state
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && product == '0, "R1", "reset outputs",
          longint'(product), 0);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 0 && done == 0 && product == '0, "R1", "after reset",
          longint'(product), 0);

    // R7: most negative squared
    issue(8'h80, 8'h80); wait_idle();
    check(product == 16'h4000, "R7", "min*min", longint'($signed(product)), 16384);

    // R6: negative multiplier
    issue(8'd37, 8'hFD); wait_idle();
    check($signed(product) == -111, "R6", "37*-3", longint'($signed(product)), -111);
    issue(8'hE7, 8'h81); wait_idle();
    check($signed(product) == 16'sd3175, "R6", "-25*-127", longint'($signed(product)), 3175);

    // R5: alternating patterns exercise every digit value
    issue(8'd1, 8'hAA); wait_idle();
    check($signed(product) == -86, "R5", "1*0xAA", longint'($signed(product)), -86);
    issue(8'd3, 8'h55); wait_idle();
    check($signed(product) == 255, "R5", "3*0x55", longint'($signed(product)), 255);

    // R8: start while busy is ignored
    issue(8'd5, 8'd7);
    mcand = 8'd9; mplier = 8'd9; start = 1'b1;
    repeat (2) @(negedge clk);
    start = 1'b0;
    wait_idle();
    check(product == 16'd35, "R8", "result after ignored start",
          longint'(product), 35);
    check(completed == issued, "R8", "done count", completed, issued);

    // R9: product holds with no request
    held = product;
    mcand = 8'h33; mplier = 8'h44;
    repeat (6) @(negedge clk);
    check(product == held && !done, "R9", "hold while idle",
          longint'(product), longint'(held));

    // R10: back-to-back acceptance in the done cycle
    issue(8'd12, 8'd11);
    t1 = last_issue;
    issue(8'hF0, 8'd3);
    check(last_issue - t1 == STEPS + 1, "R10", "issue spacing",
          last_issue - t1, STEPS + 1);
    wait_idle();

    // R4: corner grid
    foreach (vals[i]) foreach (vals[j]) issue(vals[i], vals[j]);
    wait_idle();

    // R4: random back-to-back traffic
    for (int k = 0; k < 300; k++) issue(W'($urandom), W'($urandom));
    wait_idle();

    check(completed == issued && q.size() == 0, "R4", "all results returned",
          completed, issued);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule